// File: doc/BRIEF.md
# Byte-Lane Transfer Sequencer

This block sits between a 16-bit processor data port and a system bus that can carry either one byte lane or two. For each processor request it works out how many bus cycles are needed and how wide each one is. It then runs those cycles one after another. Each cycle waits for the bus to acknowledge it. Between cycles the block emits an address-increment pulse that carries the size of the cycle just finished. The address arithmetic itself lives outside the block.

On reads it builds a 16-bit processor word out of one or two bus cycles. On writes it splits the word across cycles and places each byte on the correct bus lane. A strap input forces every cycle to be one byte wide. With the strap low, the block still uses byte cycles for a one-byte request and for any request that starts at an odd address. Only the remaining requests use two-byte cycles. The processor is told its word is complete by a one-cycle ready pulse.

Top module: `byte_lane_seq`

## Requirements
- R1: After reset no bus command, lane enable, increment pulse or ready pulse is asserted, and no request is being served.
- R2: A request runs in byte mode when the strap is high, when the count is 1, or when the start-address LSB is 1. Otherwise each cycle is two bytes wide (`bus_wide`=1) while two or more bytes remain, and the last odd byte uses a byte cycle. While the strap is high, `bus_wide` is never asserted.
- R3: In byte mode with the strap high, a two-byte read takes both bytes from `bus_din[7:0]`. The first byte lands in `proc_rdata[7:0]` and the second in `proc_rdata[15:8]`. A word made of a single byte reads back 0 in `proc_rdata[15:8]`.
- R4: A two-byte write in byte mode drives `proc_wdata[7:0]` on `bus_dout[7:0]` in the first cycle and `proc_wdata[15:8]` in the second, with `lane_en`=01.
- R5: With the strap low, a byte read at an odd address enables only the high lane (`lane_en`=10) and takes `bus_din[15:8]`. At an even address it enables only the low lane (`lane_en`=01) and takes `bus_din[7:0]`. In both cases the byte is delivered on `proc_rdata[7:0]`.
- R6: Every byte-wide write drives its byte on `bus_dout[7:0]` with `lane_en`=01. `bus_dout[15:8]` is 0.
- R7: A two-byte cycle enables both lanes (`lane_en`=11) and maps bytes straight across in both directions: `bus_dout`=`proc_wdata`, and `proc_rdata`=`bus_din`.
- R8: A bus command stays asserted until `bus_ack` is sampled high. In the following cycle the command drops and `incr_pulse` is high for one cycle, with `incr_size`=1 after a two-byte cycle and 0 after a byte cycle.
- R9: `proc_ready` pulses only together with `incr_pulse`. It pulses after a two-byte cycle, after the second byte of a byte pair, and after the final byte of a request. It does not pulse after any other cycle.
- R10: A request for N bytes runs bus cycles totalling exactly N bytes and then returns to idle.
- R11: A request with a count of 0, or any request arriving while a transfer is in progress, is ignored.
- R12: A multibyte request starting at an odd address with the strap low uses byte cycles whose read lane alternates high, low, high, following the address parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_count | input | CNT_W | Number of bytes requested |
| req_addr_lsb | input | 1 | Start address bit 0 |
| strap_8bit | input | 1 | Forces byte-wide bus cycles; held stable during a request |
| proc_wdata | input | 2*LANE_W | Processor write word, held until its ready pulse |
| proc_rdata | output | 2*LANE_W | Assembled processor read word |
| bus_din | input | 2*LANE_W | Bus read data, both lanes |
| bus_dout | output | 2*LANE_W | Bus write data, both lanes |
| bus_ack | input | 1 | Bus cycle acknowledge |
| bus_cmd_rd | output | 1 | Bus read command |
| bus_cmd_wr | output | 1 | Bus write command |
| bus_wide | output | 1 | Current cycle is two bytes wide |
| lane_en | output | 2 | Lane enables: bit 0 low lane, bit 1 high lane |
| incr_pulse | output | 1 | Address-increment request |
| incr_size | output | 1 | Increment size: 1 = two bytes, 0 = one byte |
| proc_ready | output | 1 | Processor word complete |

## Verification
Two events fall in the same cycle: the address-increment pulse for a finished bus cycle and the ready pulse that tells the processor its word is complete. This happens after every two-byte cycle and after the closing byte of a pair or of a request. In the other cycles the increment must appear alone. The bench provokes both cases with paired byte reads and writes, two-byte transfers, odd-start sequences and requests whose byte count is odd. In the single cycle after each acknowledge it checks `incr_pulse`, `incr_size`, `proc_ready` and the assembled word together. A second overlap is a new request arriving during a bus cycle, which must leave the running transfer untouched.

// File: rtl/byte_lane_seq_pkg.sv
// Shared types for the byte-lane transfer sequencer.
// Assumes nothing beyond a two-lane bus.
package byte_lane_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a request
        ST_BUS  = 2'd1,   // bus command asserted, waiting for acknowledge
        ST_ADV  = 2'd2    // one cycle between bus cycles: increment and ready
    } seq_state_t;

    localparam int NUM_LANES = 2;

endpackage

// File: rtl/byte_lane_plan.sv
// Combinational cycle planner: decides the width of the next bus cycle and
// which bus lanes it enables.
// Assumes narrow_mode was fixed when the request was accepted.
module byte_lane_plan
    import byte_lane_seq_pkg::*;
(
    input  logic                 narrow_mode,
    input  logic                 two_left,
    input  logic                 addr_odd,
    input  logic                 strap_r,
    input  logic                 is_write,
    output logic                 wide,
    output logic                 from_hi,
    output logic [NUM_LANES-1:0] lanes
);

    // Pick the cycle width and the lane set for the cycle about to run.
    always_comb begin
        wide    = !narrow_mode && two_left;
        from_hi = !wide && !is_write && !strap_r && addr_odd;
        if (wide)
            lanes = 2'b11;
        else if (from_hi)
            lanes = 2'b10;
        else
            lanes = 2'b01;
    end

endmodule

// File: rtl/byte_lane_steer.sv
// Data steering: assembles processor read words from one or two bus cycles
// and selects the write byte or word placed on the bus.
// Assumes proc_wdata stays stable for the whole processor word.
module byte_lane_steer #(
    parameter int LANE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture,
    input  logic                wide,
    input  logic                phase,
    input  logic                from_hi,
    input  logic [2*LANE_W-1:0] bus_din,
    input  logic [2*LANE_W-1:0] proc_wdata,
    output logic [2*LANE_W-1:0] rd_word,
    output logic [2*LANE_W-1:0] wr_bus
);

    localparam int BUS_W = 2 * LANE_W;

    logic [LANE_W-1:0] rd_byte;

    // Select the byte lane a byte-wide read comes from.
    always_comb rd_byte = from_hi ? bus_din[BUS_W-1:LANE_W] : bus_din[LANE_W-1:0];

    // Select what a write places on the bus lanes.
    always_comb begin
        if (wide)
            wr_bus = proc_wdata;
        else if (phase)
            wr_bus = {{LANE_W{1'b0}}, proc_wdata[BUS_W-1:LANE_W]};
        else
            wr_bus = {{LANE_W{1'b0}}, proc_wdata[LANE_W-1:0]};
    end

    // Build the processor read word on each acknowledged read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_word <= '0;
        else if (capture) begin
            if (wide)
                rd_word <= bus_din;
            else if (phase)
                rd_word[BUS_W-1:LANE_W] <= rd_byte;
            else
                rd_word <= {{LANE_W{1'b0}}, rd_byte};
        end
    end

endmodule

// File: rtl/byte_lane_seq.sv
// Byte-lane transfer sequencer top: accepts a processor request and runs
// byte or two-byte bus cycles until the byte count is used up. It pulses an
// address increment between cycles and a ready pulse per finished word.
// Assumes strap_8bit and proc_wdata stay stable while a word is in flight.
module byte_lane_seq
    import byte_lane_seq_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int LANE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [CNT_W-1:0]     req_count,
    input  logic                 req_addr_lsb,
    input  logic                 strap_8bit,
    input  logic [2*LANE_W-1:0]  proc_wdata,
    output logic [2*LANE_W-1:0]  proc_rdata,
    input  logic [2*LANE_W-1:0]  bus_din,
    output logic [2*LANE_W-1:0]  bus_dout,
    input  logic                 bus_ack,
    output logic                 bus_cmd_rd,
    output logic                 bus_cmd_wr,
    output logic                 bus_wide,
    output logic [1:0]           lane_en,
    output logic                 incr_pulse,
    output logic                 incr_size,
    output logic                 proc_ready
);

    localparam int BUS_W = 2 * LANE_W;

    seq_state_t           state;
    logic [CNT_W-1:0]     cnt_r;
    logic                 addr_odd_r;
    logic                 phase_r;
    logic                 narrow_r;
    logic                 strap_r;
    logic                 write_r;
    logic                 last_wide_r;
    logic                 word_done_r;

    logic                 accept;
    logic                 done_cyc;
    logic                 wide;
    logic                 from_hi;
    logic [NUM_LANES-1:0] lanes;
    logic [BUS_W-1:0]     wr_bus;

    // Request acceptance and bus-cycle completion strobes.
    always_comb begin
        accept   = (state == ST_IDLE) && req_valid && (req_count != '0);
        done_cyc = (state == ST_BUS) && bus_ack;
    end

    byte_lane_plan u_plan (
        .narrow_mode (narrow_r),
        .two_left    (cnt_r >= CNT_W'(2)),
        .addr_odd    (addr_odd_r),
        .strap_r     (strap_r),
        .is_write    (write_r),
        .wide        (wide),
        .from_hi     (from_hi),
        .lanes       (lanes)
    );

    byte_lane_steer #(.LANE_W(LANE_W)) u_steer (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (done_cyc && !write_r),
        .wide       (wide),
        .phase      (phase_r),
        .from_hi    (from_hi),
        .bus_din    (bus_din),
        .proc_wdata (proc_wdata),
        .rd_word    (proc_rdata),
        .wr_bus     (wr_bus)
    );

    // Sequencer state, byte counter, lane phase and address parity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            cnt_r       <= '0;
            addr_odd_r  <= 1'b0;
            phase_r     <= 1'b0;
            narrow_r    <= 1'b0;
            strap_r     <= 1'b0;
            write_r     <= 1'b0;
            last_wide_r <= 1'b0;
            word_done_r <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    state      <= ST_BUS;
                    cnt_r      <= req_count;
                    addr_odd_r <= req_addr_lsb;
                    phase_r    <= 1'b0;
                    narrow_r   <= strap_8bit || req_addr_lsb || (req_count == CNT_W'(1));
                    strap_r    <= strap_8bit;
                    write_r    <= req_write;
                end
                ST_BUS: if (done_cyc) begin
                    state       <= ST_ADV;
                    cnt_r       <= cnt_r - (wide ? CNT_W'(2) : CNT_W'(1));
                    last_wide_r <= wide;
                    word_done_r <= wide || phase_r || (cnt_r == CNT_W'(1));
                    phase_r     <= !(wide || phase_r);
                    addr_odd_r  <= wide ? addr_odd_r : !addr_odd_r;
                end
                ST_ADV: state <= (cnt_r == '0) ? ST_IDLE : ST_BUS;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Bus-side and processor-side outputs decoded from the state.
    always_comb begin
        bus_cmd_rd = (state == ST_BUS) && !write_r;
        bus_cmd_wr = (state == ST_BUS) && write_r;
        bus_wide   = (state == ST_BUS) && wide;
        lane_en    = (state == ST_BUS) ? lanes : 2'b00;
        bus_dout   = ((state == ST_BUS) && write_r) ? wr_bus : '0;
        incr_pulse = (state == ST_ADV);
        incr_size  = (state == ST_ADV) && last_wide_r;
        proc_ready = (state == ST_ADV) && word_done_r;
    end

endmodule

// File: rtl/byte_lane_seq_chk.sv
// Protocol checker for byte_lane_seq, attached by bind. It observes ports
// only and assumes the strap stays stable while a request runs.
module byte_lane_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       strap_8bit,
    input logic       bus_ack,
    input logic       bus_cmd_rd,
    input logic       bus_cmd_wr,
    input logic       bus_wide,
    input logic [1:0] lane_en,
    input logic       incr_pulse,
    input logic       proc_ready
);

    logic cmd;
    always_comb cmd = bus_cmd_rd || bus_cmd_wr;

    AST_CMD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_cmd_rd && bus_cmd_wr));                                      // R8
    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd && !bus_ack |=> $stable(bus_cmd_rd) && $stable(bus_cmd_wr) && cmd); // R8
    AST_INCR_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        cmd && bus_ack |=> incr_pulse && !cmd);                            // R8
    AST_READY_WITH_INCR: assert property (@(posedge clk) disable iff (!rst_n)
        proc_ready |-> incr_pulse);                                        // R9
    AST_WIDE_BOTH_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wide |-> cmd && (lane_en == 2'b11));                           // R7
    AST_STRAP_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        strap_8bit && cmd |-> !bus_wide);                                  // R2
    AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd && !bus_wide |-> $countones(lane_en) == 1);                    // R5
    AST_BYTE_WRITE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd_wr && !bus_wide |-> lane_en == 2'b01);                     // R6

endmodule

bind byte_lane_seq byte_lane_seq_chk u_chk (.*);

// File: tb/byte_lane_seq_test.sv
// Directed bench for byte_lane_seq: one task per scenario, each checking
// its own results. Inputs change and outputs are sampled on falling edges.
module byte_lane_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_count = '0;
    logic        req_addr_lsb = 1'b0;
    logic        strap_8bit = 1'b0;
    logic [15:0] proc_wdata = '0;
    logic [15:0] proc_rdata;
    logic [15:0] bus_din = '0;
    logic [15:0] bus_dout;
    logic        bus_ack = 1'b0;
    logic        bus_cmd_rd, bus_cmd_wr, bus_wide;
    logic [1:0]  lane_en;
    logic        incr_pulse, incr_size, proc_ready;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    byte_lane_seq uut (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one request; returns at the falling edge where the first cycle is visible.
    task automatic request(input bit wr, input logic [7:0] cnt, input bit lsb);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_count = cnt; req_addr_lsb = lsb;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Check one bus cycle, acknowledge it, then check the step cycle after it.
    task automatic bus_cyc(input string req, input bit wr, input bit exp_wide,
                           input logic [1:0] exp_lanes, input logic [15:0] exp_dout,
                           input logic [15:0] din, input int waits,
                           input bit exp_ready, input logic [15:0] exp_rdata);
        #1;
        chk(bus_cmd_rd == !wr && bus_cmd_wr == wr, req, {bus_cmd_rd, bus_cmd_wr}, {!wr, wr});
        chk(bus_wide == exp_wide, req, bus_wide, exp_wide);
        chk(lane_en == exp_lanes, req, lane_en, exp_lanes);
        if (wr) chk(bus_dout == exp_dout, req, bus_dout, exp_dout);
        for (int i = 0; i < waits; i++) begin
            @(negedge clk);
            chk((bus_cmd_rd || bus_cmd_wr) && !incr_pulse, "R8 command held", {bus_cmd_rd, bus_cmd_wr}, wr ? 2'b01 : 2'b10);
        end
        bus_ack = 1'b1; bus_din = din;
        @(negedge clk);
        bus_ack = 1'b0;
        chk(incr_pulse == 1'b1 && !bus_cmd_rd && !bus_cmd_wr, "R8 increment after ack", incr_pulse, 1);
        chk(incr_size == exp_wide, "R8 increment size", incr_size, exp_wide);
        chk(proc_ready == exp_ready, "R9 ready", proc_ready, exp_ready);
        if (exp_ready && !wr) chk(proc_rdata == exp_rdata, req, proc_rdata, exp_rdata);
        @(negedge clk);
    endtask

    task automatic expect_idle(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            #1;
            chk(!bus_cmd_rd && !bus_cmd_wr && !incr_pulse && !proc_ready && lane_en == 2'b00,
                req, {bus_cmd_rd, bus_cmd_wr, incr_pulse, proc_ready, lane_en}, 0);
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(!bus_cmd_rd && !bus_cmd_wr && !incr_pulse && !proc_ready && lane_en == 0 && !bus_wide,
            "R1 reset outputs", {bus_cmd_rd, bus_cmd_wr, incr_pulse, proc_ready, lane_en}, 0);
        chk(proc_rdata == 0 && bus_dout == 0, "R1 reset data", {proc_rdata, bus_dout}, 0);
    endtask

    task automatic t_strap_read_pair;   // R3 R2 R9 R10
        strap_8bit = 1'b1;
        request(1'b0, 8'd2, 1'b0);
        bus_cyc("R3 first byte", 0, 0, 2'b01, 0, 16'hEEAB, 2, 0, 0);
        bus_cyc("R3 pair assembled", 0, 0, 2'b01, 0, 16'h11CD, 0, 1, 16'hCDAB);
        expect_idle("R10 idle after two bytes", 2);
        request(1'b0, 8'd1, 1'b1);   // strap high, odd: still low lane
        bus_cyc("R3 single byte high half zero", 0, 0, 2'b01, 0, 16'h6677, 0, 1, 16'h0077);
        expect_idle("R10 idle after one byte", 1);
    endtask

    task automatic t_strap_write_pair;  // R4
        strap_8bit = 1'b1;
        proc_wdata = 16'h1234;
        request(1'b1, 8'd2, 1'b0);
        bus_cyc("R4 low byte first", 1, 0, 2'b01, 16'h0034, 0, 1, 0, 0);
        bus_cyc("R4 high byte second", 1, 0, 2'b01, 16'h0012, 0, 0, 1, 0);
        expect_idle("R10 idle after write pair", 1);
    endtask

    task automatic t_single_byte_wide_bus;  // R5 R6
        strap_8bit = 1'b0;
        request(1'b0, 8'd1, 1'b1);
        bus_cyc("R5 odd byte from high lane", 0, 0, 2'b10, 0, 16'h5A33, 0, 1, 16'h005A);
        request(1'b0, 8'd1, 1'b0);
        bus_cyc("R5 even byte from low lane", 0, 0, 2'b01, 0, 16'h77C3, 0, 1, 16'h00C3);
        proc_wdata = 16'hA5F0;
        request(1'b1, 8'd1, 1'b1);
        bus_cyc("R6 odd byte write on low lane", 1, 0, 2'b01, 16'h00F0, 0, 0, 1, 0);
        expect_idle("R10 idle after single write", 1);
    endtask

    task automatic t_wide_transfers;   // R7 R2 R10
        strap_8bit = 1'b0;
        request(1'b0, 8'd4, 1'b0);
        bus_cyc("R7 wide read word 1", 0, 1, 2'b11, 0, 16'h1122, 1, 1, 16'h1122);
        bus_cyc("R7 wide read word 2", 0, 1, 2'b11, 0, 16'h3344, 0, 1, 16'h3344);
        expect_idle("R10 idle after four bytes", 1);
        proc_wdata = 16'hBEEF;
        request(1'b1, 8'd3, 1'b0);
        bus_cyc("R7 wide write word", 1, 1, 2'b11, 16'hBEEF, 0, 0, 1, 0);
        proc_wdata = 16'h9942;
        bus_cyc("R2 trailing byte cycle", 1, 0, 2'b01, 16'h0042, 0, 0, 1, 0);
        expect_idle("R10 idle after three bytes", 2);
    endtask

    task automatic t_odd_start_multibyte;   // R12 R2 R9
        strap_8bit = 1'b0;
        request(1'b0, 8'd3, 1'b1);
        bus_cyc("R12 first byte high lane", 0, 0, 2'b10, 0, 16'h9912, 0, 0, 0);
        bus_cyc("R12 second byte low lane", 0, 0, 2'b01, 0, 16'h3488, 0, 1, 16'h8899);
        bus_cyc("R12 third byte high lane", 0, 0, 2'b10, 0, 16'h7756, 0, 1, 16'h0077);
        expect_idle("R10 idle after odd start", 1);
    endtask

    task automatic t_ignored_requests;   // R11
        strap_8bit = 1'b0;
        request(1'b0, 8'd0, 1'b0);
        expect_idle("R11 zero count ignored", 4);
        request(1'b0, 8'd1, 1'b0);
        req_valid = 1'b1; req_count = 8'd5; req_write = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(bus_cmd_rd && !bus_cmd_wr, "R11 busy request ignored", {bus_cmd_rd, bus_cmd_wr}, 2'b10);
        bus_cyc("R11 original read completes", 0, 0, 2'b01, 0, 16'h0011, 0, 1, 16'h0011);
        expect_idle("R11 no extra cycles", 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_strap_read_pair();
        t_strap_write_pair();
        t_single_byte_wide_bus();
        t_wide_transfers();
        t_odd_start_multibyte();
        t_ignored_requests();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule